// File: doc/BRIEF.md
# Phase-Continuous V.23 FSK Sample Generator

This block turns one serial transmit bit into a stream of signed digital sine samples for V.23 frequency-shift keying. It runs from the 3.579545 MHz master clock, divides it down to a fixed sample rate, and steps a 24-bit phase accumulator by a frequency word. The word depends on the speed mode and on the current bit. A quarter-wave sine table turns the top accumulator bits into an 8-bit two's-complement sample. One strobe cycle marks each new sample.

Changing the bit changes only the phase step, so the waveform has no phase jumps at mark/space transitions. The generator is active only when the fast/slow mode bits select one of the two speeds, the tone-select input leaves the output with the modem, and the standard-select input picks V.23. In every other state it emits mid-scale (zero) samples and clears its phase. The next enabled sample then starts from zero phase.

Top module: `fsk_modulator`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `sample_valid` is 0 and `sample_out` is 0.
- R2: `sample_valid` pulses high for one cycle once every `SAMPLE_DIV` clock cycles (default 448). The inputs used for a sample are those present 3 cycles before its strobe.
- R3: When `mode[1]` is 0 (mode 00 or 01), every sample is 0 and the phase accumulator is cleared. The first sample after re-enabling is the sine of one phase step from zero.
- R4: Mode 10 (75 bps) steps the accumulator by round(f·2^24·SAMPLE_DIV/3579545), with f = 450 Hz for `tx_bit`=0 (space) and f = 390 Hz for `tx_bit`=1 (mark).
- R5: Mode 11 (1200 bps) uses the same step formula with f = 2100 Hz for space and f = 1300 Hz for mark.
- R6: A change of `tx_bit` or of the speed mode while enabled changes only the step. The accumulator carries on from its current value, modulo 2^24.
- R7: When `tone_sel` is 1, samples are 0 and the accumulator is cleared.
- R8: When `std_sel` is 1 (non-V.23 standard), samples are 0 and the accumulator is cleared.
- R9: Each sample is taken from the accumulator value after that sample's step, top 8 bits p. Quadrant is q = p[7:6] and index is i = p[5:0]. The magnitude is T[i] for q = 0 or 2 and T[63−i] for q = 1 or 3, negated for q = 2 or 3. T[k] = floor((4064·P + D)/(2·D)), where u = 2k+1, P = u·(256−u) and D = 327680 − 4·P.
- R10: `sample_out` never equals −128; the output range is −127..127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 3.579545 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Speed mode: 0x off, 10 = 75 bps, 11 = 1200 bps |
| tx_bit | input | 1 | Data bit: 0 = space, 1 = mark |
| tone_sel | input | 1 | 1 hands the output to a tone source; this block then emits zero |
| std_sel | input | 1 | 0 = V.23 frequency pairs, 1 = other standard (this block emits zero) |
| sample_out | output | 8 | Signed sine sample |
| sample_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
A wrong frequency word or a corrupted accumulator shows at the ports on the very next strobe as a sample value off the computed sine sequence. Because the phase error accumulates, the deviation grows with each later sample. A phase reset at a bit change shows up within one sample as a jump back toward zero phase rather than continued progress. A missed clear on disable shows on the first enabled strobe as a nonzero starting phase. Divider faults move the strobe spacing away from the fixed interval at once.

// File: rtl/fsk_pkg.sv
package fsk_pkg;

  // Phase step for a tone of f_hz at sample rate clk_hz/div, rounded.
  function automatic longint freq_word(input longint f_hz, input longint clk_hz,
                                       input longint div, input int acc_w);
    longint scale;
    scale = longint'(1) << acc_w;
    return (f_hz * scale * div + clk_hz / 2) / clk_hz;
  endfunction

  // Quarter-wave magnitude for entry idx of n, rational sine approximation.
  function automatic int quarter_sine(input int idx, input int n, input int amp);
    longint half_turn, u, p, d;
    half_turn = 4 * longint'(n);
    u = 2 * longint'(idx) + 1;
    p = u * (half_turn - u);
    d = 5 * half_turn * half_turn - 4 * p;
    return int'((2 * longint'(amp) * 16 * p + d) / (2 * d));
  endfunction

endpackage

// File: rtl/fsk_sample_tick.sv
module fsk_sample_tick #(
  parameter int DIV = 448
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = $clog2(DIV);

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc #(
  parameter int ACC_W = 24,
  parameter int PH_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             enable,
  input  logic [ACC_W-1:0] step,
  output logic             ph_valid,
  output logic             ph_en,
  output logic [PH_W-1:0]  ph_top
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] acc_next;

  assign acc_next = acc + step;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      ph_valid <= 1'b0;
      ph_en    <= 1'b0;
      ph_top   <= '0;
    end else begin
      ph_valid <= tick;
      if (tick) begin
        ph_en <= enable;
        if (enable) begin
          acc    <= acc_next;
          ph_top <= acc_next[ACC_W-1 -: PH_W];
        end else begin
          acc    <= '0;
          ph_top <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/fsk_sine_lut.sv
module fsk_sine_lut
  import fsk_pkg::*;
#(
  parameter int PH_W   = 8,
  parameter int SAMP_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     in_en,
  input  logic [PH_W-1:0]          phase,
  output logic signed [SAMP_W-1:0] sample,
  output logic                     valid
);
  localparam int AW  = PH_W - 2;
  localparam int N   = 1 << AW;
  localparam int MW  = SAMP_W - 1;
  localparam int AMP = (1 << MW) - 1;

  logic [MW-1:0] rom [N];

  for (genvar g = 0; g < N; g++) begin : g_rom
    assign rom[g] = MW'(quarter_sine(g, N, AMP));
  end

  logic [AW-1:0] addr;
  logic [MW-1:0] mag;
  logic          s_neg, s_en, s_v;

  assign addr = phase[PH_W-2] ? ~phase[AW-1:0] : phase[AW-1:0];

  always_ff @(posedge clk) begin
    mag <= rom[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_neg  <= 1'b0;
      s_en   <= 1'b0;
      s_v    <= 1'b0;
      sample <= '0;
      valid  <= 1'b0;
    end else begin
      s_neg <= phase[PH_W-1];
      s_en  <= in_en;
      s_v   <= in_valid;
      valid <= s_v;
      if (!s_en)     sample <= '0;
      else if (s_neg) sample <= -$signed({1'b0, mag});
      else            sample <= $signed({1'b0, mag});
    end
  end
endmodule

// File: rtl/fsk_modulator.sv
module fsk_modulator
  import fsk_pkg::*;
#(
  parameter int     ACC_W       = 24,
  parameter int     PH_W        = 8,
  parameter int     SAMP_W      = 8,
  parameter int     SAMPLE_DIV  = 448,
  parameter longint CLK_HZ      = 3579545,
  parameter longint F_SLOW_SPC  = 450,
  parameter longint F_SLOW_MRK  = 390,
  parameter longint F_FAST_SPC  = 2100,
  parameter longint F_FAST_MRK  = 1300
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               mode,
  input  logic                     tx_bit,
  input  logic                     tone_sel,
  input  logic                     std_sel,
  output logic signed [SAMP_W-1:0] sample_out,
  output logic                     sample_valid
);
  localparam logic [ACC_W-1:0] W_SLOW_SPC = ACC_W'(freq_word(F_SLOW_SPC, CLK_HZ, SAMPLE_DIV, ACC_W));
  localparam logic [ACC_W-1:0] W_SLOW_MRK = ACC_W'(freq_word(F_SLOW_MRK, CLK_HZ, SAMPLE_DIV, ACC_W));
  localparam logic [ACC_W-1:0] W_FAST_SPC = ACC_W'(freq_word(F_FAST_SPC, CLK_HZ, SAMPLE_DIV, ACC_W));
  localparam logic [ACC_W-1:0] W_FAST_MRK = ACC_W'(freq_word(F_FAST_MRK, CLK_HZ, SAMPLE_DIV, ACC_W));

  logic             tick;
  logic             enable;
  logic [ACC_W-1:0] step;
  logic             ph_valid, ph_en;
  logic [PH_W-1:0]  ph_top;

  assign enable = mode[1] & ~tone_sel & ~std_sel;

  always_comb begin
    case ({mode[0], tx_bit})
      2'b00:   step = W_SLOW_SPC;
      2'b01:   step = W_SLOW_MRK;
      2'b10:   step = W_FAST_SPC;
      default: step = W_FAST_MRK;
    endcase
  end

  fsk_sample_tick #(.DIV(SAMPLE_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  fsk_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .enable   (enable),
    .step     (step),
    .ph_valid (ph_valid),
    .ph_en    (ph_en),
    .ph_top   (ph_top)
  );

  fsk_sine_lut #(.PH_W(PH_W), .SAMP_W(SAMP_W)) u_lut (
    .clk      (clk),
    .rst      (rst),
    .in_valid (ph_valid),
    .in_en    (ph_en),
    .phase    (ph_top),
    .sample   (sample_out),
    .valid    (sample_valid)
  );
endmodule

// File: rtl/fsk_modulator_chk.sv
module fsk_modulator_chk #(
  parameter int SAMPLE_DIV = 448,
  parameter int SAMP_W     = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     mode_hi,
  input logic                     tone_sel,
  input logic                     std_sel,
  input logic signed [SAMP_W-1:0] sample_out,
  input logic                     sample_valid
);
  localparam int CW = $clog2(SAMPLE_DIV) + 1;

  logic [CW-1:0] gap;
  logic          seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (sample_valid) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != {CW{1'b1}}) begin
      gap <= gap + 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!sample_valid && sample_out == '0));

  assert_strobe_period_R2: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && seen) |-> (gap == CW'(SAMPLE_DIV - 1)));

  assert_off_mode_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && !$past(mode_hi, 3)) |-> (sample_out == '0));

  assert_tone_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && $past(tone_sel, 3)) |-> (sample_out == '0));

  assert_std_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && $past(std_sel, 3)) |-> (sample_out == '0));

  assert_no_min_code_R10: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> (sample_out != {1'b1, {(SAMP_W-1){1'b0}}}));

  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);
endmodule

bind fsk_modulator fsk_modulator_chk #(
  .SAMPLE_DIV (SAMPLE_DIV),
  .SAMP_W     (SAMP_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mode_hi      (mode[1]),
  .tone_sel     (tone_sel),
  .std_sel      (std_sel),
  .sample_out   (sample_out),
  .sample_valid (sample_valid)
);

// File: tb/test_fsk_modulator.sv
module test_fsk_modulator;
  localparam int     DIV  = 448;
  localparam longint CLKF = 3579545;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        mode = 2'b00;
  logic              tx_bit = 1'b0;
  logic              tone_sel = 1'b0;
  logic              std_sel = 1'b0;
  logic signed [7:0] sample_out;
  logic              sample_valid;

  int checks = 0;
  int fails  = 0;
  int     exp_q[$];
  string  tag_q[$];
  longint macc = 0;
  int     gap = 0;
  bit     seen = 0;
  bit     done = 0;

  always #10 clk = ~clk;

  fsk_modulator i_fsk_modulator (
    .clk (clk), .rst (rst), .mode (mode), .tx_bit (tx_bit),
    .tone_sel (tone_sel), .std_sel (std_sel),
    .sample_out (sample_out), .sample_valid (sample_valid)
  );

  function automatic longint step_of(input bit fast, input bit mark);
    longint f;
    if (fast) f = mark ? 1300 : 2100;
    else      f = mark ? 390 : 450;
    return (f * (longint'(1) << 24) * DIV + CLKF / 2) / CLKF;
  endfunction

  function automatic int tbl(input int k);
    longint u, p, d;
    u = 2 * k + 1;
    p = u * (256 - u);
    d = 327680 - 4 * p;
    return int'((4064 * p + d) / (2 * d));
  endfunction

  function automatic int sine8(input int p);
    int q, i, m;
    q = (p >> 6) & 3;
    i = p & 63;
    m = (q % 2 == 1) ? tbl(63 - i) : tbl(i);
    return (q >= 2) ? -m : m;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: set inputs, push n expected samples, wait for them.
  task automatic drive(input logic [1:0] m, input bit d, input bit t, input bit s,
                       input int n, input string tag);
    mode = m; tx_bit = d; tone_sel = t; std_sel = s;
    for (int k = 0; k < n; k++) begin
      if (m[1] && !t && !s) begin
        macc = (macc + step_of(m[0], d)) & 64'hFFFFFF;
        exp_q.push_back(sine8(int'(macc >> 16)));
      end else begin
        macc = 0;
        exp_q.push_back(0);
      end
      tag_q.push_back(tag);
    end
    for (int k = 0; k < n; k++) begin
      do @(negedge clk); while (!sample_valid);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      gap++;
      if (sample_valid) begin
        if (seen) check(gap == DIV, "R2 strobe spacing", gap, DIV);
        seen = 1;
        gap = 0;
        if (exp_q.size() == 0) begin
          check(0, "R2 unexpected sample", sample_out, 0);
        end else begin
          int e;
          string tg;
          e  = exp_q.pop_front();
          tg = tag_q.pop_front();
          check(int'(sample_out) == e, tg, int'(sample_out), e);
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(sample_valid == 1'b0, "R1 reset valid", sample_valid, 0);
    check(sample_out == 8'sd0, "R1 reset sample", sample_out, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(sample_valid == 1'b0, "R1 after reset valid", sample_valid, 0);
    check(sample_out == 8'sd0, "R1 after reset sample", sample_out, 0);

    drive(2'b00, 1'b1, 0, 0, 6, "R3 mode 00 zero");
    drive(2'b01, 1'b0, 0, 0, 4, "R3 mode 01 zero");
    drive(2'b10, 1'b1, 0, 0, 40, "R4 75bps mark / R9 shape");
    drive(2'b10, 1'b0, 0, 0, 40, "R4 75bps space R6 continuity");
    drive(2'b11, 1'b0, 0, 0, 30, "R5 1200bps space R6 continuity");
    drive(2'b11, 1'b1, 0, 0, 30, "R5 1200bps mark / R9 shape");
    for (int r = 0; r < 10; r++)
      drive(2'b11, r[0], 0, 0, 3, "R6 alternating bits");
    drive(2'b11, 1'b1, 1, 0, 5, "R7 tone select zero");
    drive(2'b11, 1'b0, 0, 0, 8, "R3 restart from zero phase");
    drive(2'b10, 1'b0, 0, 1, 5, "R8 std select zero");
    drive(2'b10, 1'b0, 0, 0, 8, "R3 R8 restart after std");
    drive(2'b00, 1'b0, 0, 0, 4, "R3 disable again");
    drive(2'b11, 1'b1, 0, 0, 20, "R3 R5 re-enable mark");

    repeat (5) @(negedge clk);
    done = 1;
    check(exp_q.size() == 0, "R2 all samples produced", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule